// File: doc/BRIEF.md
# Per-Port Congestion Flow Controller

This block sits beside one switch port's MAC and turns a buffer-congestion flag into action toward the link partner. On a full-duplex link it asks the MAC to send IEEE 802.3x PAUSE frames. The first request carries the full pause time. While congestion lasts, the request is repeated once half of that time has run out. When congestion clears, one request with zero pause time releases the partner. On a half-duplex link it instead raises a jam enable, which makes the MAC hold the carrier busy (backpressure).

Half-duplex backpressure has two modes, picked by a strap input. In the collision-limited mode, jamming gives up once the count of consecutive collisions reaches a programmable limit. In the persistent mode, jamming continues for at most a fixed number of slot times while congestion remains. A half-duplex disable bit turns backpressure off altogether. An option bit decides whether pause frames depend on the autonegotiated partner pause ability.

The pause request is a valid/ready stream toward the MAC transmitter. Once `pause_valid` rises, it stays high and `pause_quanta` stays unchanged until a cycle in which `pause_ready` is also high. That cycle is the handshake. The MAC may hold `pause_ready` low for as long as it needs, and the block loses no request while it waits. All other pins are plain levels or single-cycle pulses sampled on the rising clock edge.

Top module: `fc_port_engine`

## Requirements
- R1: After reset, `pause_valid` and `jam_en` are both 0.
- R2: In full duplex with pause permitted, a rising congestion flag makes `pause_valid` rise one cycle later with `pause_quanta` = PAUSE_QUANTA (default 2048). Every request carries either that value or 0.
- R3: While `pause_valid` is 1 and `pause_ready` is 0, `pause_valid` stays 1 and `pause_quanta` keeps its value on the next cycle.
- R4: Pause is permitted when `aneg_honour` = 0, or when `aneg_honour` = 1 and `partner_pause` = 1. Otherwise no non-zero request starts.
- R5: After a non-zero request is accepted, congestion clearing (or pause ceasing to be permitted) produces exactly one request with `pause_quanta` = 0, and then no more requests.
- R6: While congestion persists after an accepted non-zero request, a new non-zero request rises after exactly PAUSE_QUANTA/2 `slot_tick` pulses and not before.
- R7: In half duplex with `hd_fc_off` = 0, congestion raises `jam_en` one cycle later. With `hd_fc_off` = 1, `jam_en` stays 0.
- R8: With `bp_persist` = 0, `jam_en` falls one cycle after the cycle in which the consecutive-collision count reaches `coll_limit`. It stays 0 while congestion persists without a clean transmission.
- R9: A `tx_ok` pulse or congestion clearing resets the consecutive-collision count, so `jam_en` returns after a `tx_ok`.
- R10: With `bp_persist` = 1, collisions do not stop `jam_en`. It falls one cycle after BP_SLOT_MAX `slot_tick` pulses have been counted during congestion.
- R11: `jam_en` is 0 in the cycle after `full_duplex` is 1. A non-zero pause request never starts in half duplex.
- R12: `jam_en` is 0 in the cycle after `congested` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| congested | input | 1 | Buffer congestion flag for this port |
| full_duplex | input | 1 | 1 = full-duplex link, 0 = half duplex |
| collision | input | 1 | One-cycle pulse per collision seen |
| tx_ok | input | 1 | One-cycle pulse per frame sent without collision |
| slot_tick | input | 1 | One-cycle pulse per slot time (one pause quantum) |
| hd_fc_off | input | 1 | 1 disables half-duplex backpressure |
| bp_persist | input | 1 | 1 = slot-time bounded backpressure, 0 = collision-limited |
| aneg_honour | input | 1 | 1 = pause only if partner advertised pause |
| partner_pause | input | 1 | Negotiated partner pause ability |
| coll_limit | input | COLL_W | Consecutive-collision limit (e.g. 30) |
| pause_ready | input | 1 | MAC accepts the pause request |
| pause_valid | output | 1 | Pause request pending |
| pause_quanta | output | QW | Pause time of the pending request |
| jam_en | output | 1 | Carrier jam (backpressure) enable |

## Verification
A pause state machine stuck in a waiting state shows at the ports within one cycle. Either `pause_valid` stays high after the handshake, or the zero-quanta release never appears on the cycle after congestion clears. A refresh timer that is off by one moves the repeated request by one cycle relative to the 1024th slot tick, so the bench samples exactly at that boundary. A collision or slot counter holding a stale value shows one cycle after the deciding collision, `tx_ok` or slot tick, as `jam_en` staying high or low when it should change.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    PS_IDLE     = 2'd0,
    PS_SEND_ON  = 2'd1,
    PS_PAUSED   = 2'd2,
    PS_SEND_OFF = 2'd3
  } pause_st_t;
endpackage

// File: rtl/fc_pause_gen.sv
module fc_pause_gen #(
  parameter int QW           = 16,
  parameter int PAUSE_QUANTA = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_duplex,
  input  logic          congested,
  input  logic          pause_ok,
  input  logic          slot_tick,
  input  logic          ready,
  output logic          valid,
  output logic [QW-1:0] quanta
);
  import fc_pkg::*;

  localparam int REFRESH = (PAUSE_QUANTA / 2 > 0) ? PAUSE_QUANTA / 2 : 1;
  localparam int TMR_W   = $clog2(REFRESH + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REFRESH - 1);

  pause_st_t        st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             want_pause;

  assign want_pause = full_duplex && congested && pause_ok;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    unique case (st_q)
      PS_IDLE: begin
        if (want_pause) st_d = PS_SEND_ON;
      end
      PS_SEND_ON: begin
        if (ready) begin
          st_d  = PS_PAUSED;
          tmr_d = '0;
        end
      end
      PS_PAUSED: begin
        if (!want_pause) begin
          st_d = PS_SEND_OFF;
        end else if (slot_tick) begin
          if (tmr_q == TMR_LAST) st_d = PS_SEND_ON;
          else                   tmr_d = tmr_q + 1'b1;
        end
      end
      PS_SEND_OFF: begin
        if (ready) st_d = PS_IDLE;
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign valid  = (st_q == PS_SEND_ON) || (st_q == PS_SEND_OFF);
  assign quanta = (st_q == PS_SEND_ON) ? QW'(PAUSE_QUANTA) : '0;
endmodule

// File: rtl/fc_backpressure.sv
module fc_backpressure #(
  parameter int COLL_W      = 8,
  parameter int BP_SLOT_MAX = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd_active,
  input  logic              congested,
  input  logic              collision,
  input  logic              tx_ok,
  input  logic              slot_tick,
  input  logic              bp_persist,
  input  logic [COLL_W-1:0] coll_limit,
  output logic              jam_en
);
  localparam int SLOT_W = $clog2(BP_SLOT_MAX + 1);
  localparam logic [SLOT_W-1:0] SLOT_CAP = SLOT_W'(BP_SLOT_MAX);
  localparam logic [COLL_W-1:0] COLL_SAT = '1;

  logic [COLL_W-1:0] coll_cnt_q;
  logic [SLOT_W-1:0] slot_cnt_q;
  logic              within_q;
  logic              jam_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coll_cnt_q <= '0;
    end else if (!congested || tx_ok) begin
      coll_cnt_q <= '0;
    end else if (collision && coll_cnt_q != COLL_SAT) begin
      coll_cnt_q <= coll_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_cnt_q <= '0;
    end else if (!hd_active) begin
      slot_cnt_q <= '0;
    end else if (slot_tick && slot_cnt_q != SLOT_CAP) begin
      slot_cnt_q <= slot_cnt_q + 1'b1;
    end
  end

  generate
    if (BP_SLOT_MAX > 0) begin : g_slot_bound
      always_comb within_q = bp_persist ? (slot_cnt_q < SLOT_CAP)
                                        : (coll_cnt_q < coll_limit);
    end else begin : g_no_slot_bound
      always_comb within_q = bp_persist ? 1'b0 : (coll_cnt_q < coll_limit);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) jam_q <= 1'b0;
    else        jam_q <= hd_active && within_q;
  end

  assign jam_en = jam_q;
endmodule

// File: rtl/fc_port_engine.sv
module fc_port_engine #(
  parameter int QW           = 16,
  parameter int PAUSE_QUANTA = 2048,
  parameter int COLL_W       = 8,
  parameter int BP_SLOT_MAX  = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              congested,
  input  logic              full_duplex,
  input  logic              collision,
  input  logic              tx_ok,
  input  logic              slot_tick,
  input  logic              hd_fc_off,
  input  logic              bp_persist,
  input  logic              aneg_honour,
  input  logic              partner_pause,
  input  logic [COLL_W-1:0] coll_limit,
  input  logic              pause_ready,
  output logic              pause_valid,
  output logic [QW-1:0]     pause_quanta,
  output logic              jam_en
);
  logic pause_ok;
  logic hd_active;

  assign pause_ok  = !aneg_honour || partner_pause;
  assign hd_active = !full_duplex && !hd_fc_off && congested;

  fc_pause_gen #(
    .QW          (QW),
    .PAUSE_QUANTA(PAUSE_QUANTA)
  ) u_pause (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_duplex(full_duplex),
    .congested  (congested),
    .pause_ok   (pause_ok),
    .slot_tick  (slot_tick),
    .ready      (pause_ready),
    .valid      (pause_valid),
    .quanta     (pause_quanta)
  );

  fc_backpressure #(
    .COLL_W     (COLL_W),
    .BP_SLOT_MAX(BP_SLOT_MAX)
  ) u_bp (
    .clk       (clk),
    .rst_n     (rst_n),
    .hd_active (hd_active),
    .congested (congested),
    .collision (collision),
    .tx_ok     (tx_ok),
    .slot_tick (slot_tick),
    .bp_persist(bp_persist),
    .coll_limit(coll_limit),
    .jam_en    (jam_en)
  );
endmodule

// File: rtl/fc_port_engine_chk.sv
module fc_port_engine_chk #(
  parameter int QW           = 16,
  parameter int PAUSE_QUANTA = 2048,
  parameter int COLL_W       = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              congested,
  input logic              full_duplex,
  input logic              hd_fc_off,
  input logic              aneg_honour,
  input logic              partner_pause,
  input logic              pause_ready,
  input logic              pause_valid,
  input logic [QW-1:0]     pause_quanta,
  input logic              jam_en
);
  // R3: request held until accepted
  a_r3_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pause_valid && !pause_ready |=> pause_valid && $stable(pause_quanta));

  // R2: only full or zero pause time is ever offered
  a_r2_quanta_values: assert property (@(posedge clk) disable iff (!rst_n)
    pause_valid |-> (pause_quanta == QW'(PAUSE_QUANTA) || pause_quanta == '0));

  // R4 and R11: a non-zero request starts only when permitted and in full duplex
  a_r4_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_valid) && pause_quanta != '0 |->
      $past(full_duplex && congested && (!aneg_honour || partner_pause)));

  // R11: no jamming on a full-duplex link
  a_r11_no_jam_fd: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |=> !jam_en);

  // R7: disabled half-duplex flow control never jams
  a_r7_hd_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    hd_fc_off |=> !jam_en);

  // R12: jamming stops once congestion clears
  a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
    !congested |=> !jam_en);
endmodule

bind fc_port_engine fc_port_engine_chk #(
  .QW          (QW),
  .PAUSE_QUANTA(PAUSE_QUANTA),
  .COLL_W      (COLL_W)
) u_chk (.*);

// File: tb/fc_port_engine_bench.sv
module fc_port_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QW = 16;
  localparam int PQ = 2048;
  localparam int COLL_W = 8;
  localparam int SLOTS = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic congested = 0, full_duplex = 0, collision = 0, tx_ok = 0, slot_tick = 0;
  logic hd_fc_off = 0, bp_persist = 0, aneg_honour = 0, partner_pause = 0;
  logic [COLL_W-1:0] coll_limit = 8'd30;
  logic pause_ready = 0;
  logic pause_valid;
  logic [QW-1:0] pause_quanta;
  logic jam_en;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_port_engine #(.QW(QW), .PAUSE_QUANTA(PQ), .COLL_W(COLL_W), .BP_SLOT_MAX(SLOTS))
    u_fc_port_engine (.*);

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic accept();
    pause_ready = 1; step(1); pause_ready = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; step(2);
    chk("R1 valid", pause_valid, 0);
    chk("R1 jam", jam_en, 0);
    rst_n = 1; step(1);
  endtask

  task automatic t_fd_pause();
    full_duplex = 1; aneg_honour = 0; congested = 1; step(1);
    chk("R2 valid", pause_valid, 1);
    chk("R2 quanta", pause_quanta, PQ);
    step(3);
    chk("R3 held valid", pause_valid, 1);
    chk("R3 held quanta", pause_quanta, PQ);
    chk("R11 no jam fd", jam_en, 0);
    accept();
    chk("R2 accepted", pause_valid, 0);
    slot_tick = 1;
    step(PQ/2 - 1);
    chk("R6 not early", pause_valid, 0);
    step(1);
    chk("R6 refresh", pause_valid, 1);
    chk("R6 quanta", pause_quanta, PQ);
    slot_tick = 0;
    accept();
    congested = 0; step(1);
    chk("R5 release valid", pause_valid, 1);
    chk("R5 release quanta", pause_quanta, 0);
    accept();
    step(3);
    chk("R5 idle after", pause_valid, 0);
  endtask

  task automatic t_aneg();
    full_duplex = 1; aneg_honour = 1; partner_pause = 0; congested = 1; step(5);
    chk("R4 blocked", pause_valid, 0);
    partner_pause = 1; step(1);
    chk("R4 allowed", pause_valid, 1);
    chk("R4 quanta", pause_quanta, PQ);
    accept();
    partner_pause = 0; step(1);
    chk("R5 lost ability release", pause_quanta, 0);
    chk("R5 lost ability valid", pause_valid, 1);
    accept();
    congested = 0; aneg_honour = 0; step(2);
    chk("R5 quiet", pause_valid, 0);
  endtask

  task automatic pulse_coll(input int n);
    for (int i = 0; i < n; i++) begin
      collision = 1; step(1); collision = 0; step(1);
    end
  endtask

  task automatic t_hd_limit();
    full_duplex = 0; hd_fc_off = 0; bp_persist = 0; coll_limit = 8'd3;
    congested = 1; step(1);
    chk("R7 jam on", jam_en, 1);
    chk("R11 no pause hd", pause_valid, 0);
    pulse_coll(2);
    chk("R8 below limit", jam_en, 1);
    pulse_coll(1);
    chk("R8 limit reached", jam_en, 0);
    step(5);
    chk("R8 stays off", jam_en, 0);
    tx_ok = 1; step(1); tx_ok = 0; step(1);
    chk("R9 tx_ok resumes", jam_en, 1);
    pulse_coll(3);
    chk("R9 counted again", jam_en, 0);
    congested = 0; step(1);
    chk("R12 drop", jam_en, 0);
    congested = 1; step(2);
    chk("R9 congestion clear resets", jam_en, 1);
    congested = 0; step(1);
    chk("R12 drop again", jam_en, 0);
  endtask

  task automatic t_hd_off();
    hd_fc_off = 1; congested = 1; step(4);
    chk("R7 disabled", jam_en, 0);
    congested = 0; hd_fc_off = 0; step(1);
  endtask

  task automatic t_hd_persist();
    bp_persist = 1; coll_limit = 8'd2; congested = 1; step(1);
    chk("R10 jam on", jam_en, 1);
    pulse_coll(10);
    chk("R10 collisions ignored", jam_en, 1);
    slot_tick = 1; step(SLOTS);
    chk("R10 before bound", jam_en, 1);
    step(1);
    chk("R10 bound reached", jam_en, 0);
    slot_tick = 0;
    full_duplex = 1; step(1);
    chk("R11 fd clears jam", jam_en, 0);
    congested = 0; step(1);
    accept(); accept();
    full_duplex = 0; bp_persist = 0;
  endtask

  initial begin
    step(1);
    t_reset();
    t_fd_pause();
    t_aneg();
    t_hd_limit();
    t_hd_off();
    t_hd_persist();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule